// File: doc/BRIEF.md
# Interrupt Status Aggregation Controller

This block gathers interrupt events from the transmit and receive engines, plus the level outputs of several lower-level status sources, into one 32-bit status word. Software reads that word over a simple register bus. Event bits are latched from single-cycle pulses. A normal status read returns the word and then clears the latched events. A second, alias status address returns the same word but clears only the events chosen by a programmable clear-select register. This lets a polling routine consume some events and leave the others pending.

Level bits copy their sources and fall only when the source falls. The upper field carries a live copy of the transmit completion index so that one read returns both the cause and the progress. A mask register holds one bit per source and resets to all ones, so every source starts masked. The block raises an active-high interrupt request when any unmasked source bit is set, and it mirrors that request into a summary bit of the status word and onto a summary output.

The register bus is single-cycle. Read data is combinational from the address during the cycle in which the read strobe is high, and any clearing takes effect at the clock edge that ends that cycle. Reset is synchronous and active high.

Top module: `irq_status_agg`

## Requirements
- R1: After reset the status word reads 0, the mask register reads 0x0007E3FF, the clear-select register reads 0, and irq and summary are 0. Word addresses: 0 status, 1 mask, 2 clear-select, 3 alias status; any other address reads 0.
- R2: A high level on evt_pulse[i] (i in 0..9) in one cycle sets status bit i, and the bit is visible from the next cycle onward until it is cleared.
- R3: A read of address 0 returns the current status word, and at the end of that cycle status bits 0..9 are cleared.
- R4: Status bits 18:13 show src_level[5:0] as sampled one cycle earlier. No read clears them.
- R5: Status bits 31:19 show txc_index[12:0] as sampled one cycle earlier. No read clears them.
- R6: A read of address 3 returns the same word as a read of address 0, but clears only those of bits 0..9 whose bit is 1 in the clear-select register.
- R7: irq is 1 in the cycle after any of status bits 0..9 or 13..18 is 1 while the mask bit in the same position is 0. Otherwise irq is 0 in that next cycle. A mask bit of 1 blocks its source.
- R8: Status bit 12 and the summary output are equal to irq in every cycle.
- R9: If a pulse arrives in the same cycle as a read that would clear that bit, the bit is set after the read. The read data shows the value from before the read.
- R10: Status bits 10 and 11 always read 0. Writes to addresses 0 and 3 have no effect. Mask bits other than 0..9 and 13..18, and clear-select bits other than 0..9, read 0 whatever is written.
- R11: A write to address 1 or 2 loads the mask or the clear-select register from bus_wdata at the end of the cycle. The new value reads back from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 10 | Single-cycle event pulses for status bits 0..9 |
| src_level | input | 6 | Level outputs of lower-level status sources for bits 13..18 |
| txc_index | input | 13 | Transmit completion index copied into bits 31:19 |
| bus_addr | input | 4 | Word address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; has clearing side effects at addresses 0 and 3 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, combinational |
| irq | output | 1 | Active-high interrupt request |
| summary | output | 1 | Copy of the interrupt request for polling logic |

## Verification
A wrong latched event shows up in the status read data of the very next read. It also shows on irq one cycle after the bad state begins, because the request is a registered OR of the unmasked bits. The bench runs a reference model in step with the design and compares irq, summary and the read data for the current address on every clock. A lost event, a clear that hits the wrong bits, or a stale mask therefore shows within one or two cycles rather than only at a later directed read. Directed sequences cover the cases where the source bit order and the cycle order matter: a pulse that meets a clearing read, alias clearing that is partial, level bits that survive reads, and the delay from an unmasked source to the request.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int STAT_W    = 32;
    localparam int EVT_N     = 10;
    localparam int LVL_N     = 6;
    localparam int IDX_W     = 13;
    localparam int SUM_POS   = 12;
    localparam int LVL_LO    = SUM_POS + 1;
    localparam int IDX_LO    = LVL_LO + LVL_N;
    localparam int GAP_W     = SUM_POS - EVT_N;

    // positions that may drive the interrupt request
    localparam logic [STAT_W-1:0] SRC_BITS =
        {{IDX_W{1'b0}}, {LVL_N{1'b1}}, 1'b0, {GAP_W{1'b0}}, {EVT_N{1'b1}}};

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_MASK   = 2'd1,
        SEL_CLRSEL = 2'd2,
        SEL_ALIAS  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic rd_plain;
        logic rd_alias;
        logic wr_mask;
        logic wr_clrsel;
    } bus_op_t;

    function automatic logic [STAT_W-1:0] pack_status(
        input logic [EVT_N-1:0] ev,
        input logic [LVL_N-1:0] lvl,
        input logic             sum,
        input logic [IDX_W-1:0] idx
    );
        return {idx, lvl, sum, {GAP_W{1'b0}}, ev};
    endfunction

endpackage

// File: rtl/irq_evt_bank.sv
module irq_evt_bank
    import irq_agg_pkg::*;
#(
    parameter int N = EVT_N
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pulse,
    input  logic         clr_all,
    input  logic         clr_alias,
    input  logic [N-1:0] clr_sel,
    output logic [N-1:0] ev_q
);

    logic [N-1:0] clr_vec;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_comb clr_vec[i] = clr_all | (clr_alias & clr_sel[i]);

        always_ff @(posedge clk) begin
            if (rst)
                ev_q[i] <= 1'b0;
            else
                ev_q[i] <= (ev_q[i] & ~clr_vec[i]) | pulse[i];
        end
    end

    // R3
    plain_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr_all |=> (ev_q == $past(pulse)));

    // R9
    pulse_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (|pulse) |=> ((ev_q & $past(pulse)) == $past(pulse)));

    // R6
    alias_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_alias && !clr_all) |=>
        ((ev_q & ~$past(clr_sel)) == (($past(ev_q) | $past(pulse)) & ~$past(clr_sel))));

    // R6
    alias_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_alias && !clr_all) |=>
        ((ev_q & $past(clr_sel)) == ($past(pulse) & $past(clr_sel))));

endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs
    import irq_agg_pkg::*;
#(
    parameter int N = EVT_N
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_mask,
    input  logic              wr_clrsel,
    input  logic [STAT_W-1:0] wdata,
    output logic [STAT_W-1:0] mask_q,
    output logic [N-1:0]      clrsel_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q   <= SRC_BITS;
            clrsel_q <= '0;
        end else begin
            if (wr_mask)
                mask_q <= wdata & SRC_BITS;
            if (wr_clrsel)
                clrsel_q <= wdata[N-1:0];
        end
    end

    // R1
    reset_value_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ((mask_q == SRC_BITS) && (clrsel_q == '0)));

    // R10
    mask_impl_chk: assert property (@(posedge clk) disable iff (rst)
        (mask_q & ~SRC_BITS) == '0);

endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen
    import irq_agg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [STAT_W-1:0] status,
    input  logic [STAT_W-1:0] mask,
    output logic              irq_q
);

    logic [STAT_W-1:0] live;

    always_comb live = status & SRC_BITS & ~mask;

    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= 1'b0;
        else
            irq_q <= |live;
    end

    // R7
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ((status & ~mask & SRC_BITS) == '0) |=> !irq_q);

    // R7
    irq_fire_chk: assert property (@(posedge clk) disable iff (rst)
        ((status & ~mask & SRC_BITS) != '0) |=> irq_q);

endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
    import irq_agg_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [EVT_N-1:0]  evt_pulse,
    input  logic [LVL_N-1:0]  src_level,
    input  logic [IDX_W-1:0]  txc_index,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [STAT_W-1:0] bus_wdata,
    output logic [STAT_W-1:0] bus_rdata,
    output logic              irq,
    output logic              summary
);

    localparam int SEL_W = 2;

    logic              addr_ok;
    reg_sel_e          sel;
    bus_op_t           op;
    logic [EVT_N-1:0]  ev_q;
    logic [LVL_N-1:0]  lvl_q;
    logic [IDX_W-1:0]  idx_q;
    logic [STAT_W-1:0] mask_q;
    logic [EVT_N-1:0]  clrsel_q;
    logic              irq_q;
    logic [STAT_W-1:0] status;

    always_comb begin
        addr_ok = (bus_addr[ADDR_W-1:SEL_W] == '0);
        sel     = reg_sel_e'(bus_addr[SEL_W-1:0]);
        op.rd_plain  = bus_rd & addr_ok & (sel == SEL_STATUS);
        op.rd_alias  = bus_rd & addr_ok & (sel == SEL_ALIAS);
        op.wr_mask   = bus_wr & addr_ok & (sel == SEL_MASK);
        op.wr_clrsel = bus_wr & addr_ok & (sel == SEL_CLRSEL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= '0;
            idx_q <= '0;
        end else begin
            lvl_q <= src_level;
            idx_q <= txc_index;
        end
    end

    irq_evt_bank #(.N(EVT_N)) u_evt (
        .clk       (clk),
        .rst       (rst),
        .pulse     (evt_pulse),
        .clr_all   (op.rd_plain),
        .clr_alias (op.rd_alias),
        .clr_sel   (clrsel_q),
        .ev_q      (ev_q)
    );

    irq_mask_regs #(.N(EVT_N)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_mask   (op.wr_mask),
        .wr_clrsel (op.wr_clrsel),
        .wdata     (bus_wdata),
        .mask_q    (mask_q),
        .clrsel_q  (clrsel_q)
    );

    always_comb status = pack_status(ev_q, lvl_q, irq_q, idx_q);

    irq_req_gen u_req (
        .clk    (clk),
        .rst    (rst),
        .status (status),
        .mask   (mask_q),
        .irq_q  (irq_q)
    );

    always_comb begin
        bus_rdata = '0;
        if (addr_ok) begin
            unique case (sel)
                SEL_STATUS, SEL_ALIAS: bus_rdata = status;
                SEL_MASK:              bus_rdata = mask_q;
                SEL_CLRSEL:            bus_rdata = {{(STAT_W-EVT_N){1'b0}}, clrsel_q};
                default:               bus_rdata = '0;
            endcase
        end
    end

    assign irq     = irq_q;
    assign summary = irq_q;

    // R10
    gap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        status[SUM_POS-1:EVT_N] == '0);

    // R4
    level_track_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (status[IDX_LO-1:LVL_LO] == $past(src_level)));

endmodule

// File: tb/irq_status_agg_bench.sv
module irq_status_agg_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [9:0]  evt_pulse;
    logic [5:0]  src_level;
    logic [12:0] txc_index;
    logic [3:0]  bus_addr;
    logic        bus_wr;
    logic        bus_rd;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        summary;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    irq_status_agg u_irq_status_agg (
        .clk       (clk),
        .rst       (rst),
        .evt_pulse (evt_pulse),
        .src_level (src_level),
        .txc_index (txc_index),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .summary   (summary)
    );

    localparam logic [31:0] IMPL = 32'h0007E3FF;

    // reference model state
    logic [9:0]  m_ev;
    logic [5:0]  m_lvl;
    logic [12:0] m_txc;
    logic        m_irq;
    logic [31:0] m_mask;
    logic [9:0]  m_clr;
    logic [31:0] t_st;
    logic [9:0]  t_cl;
    logic        t_irq;

    function automatic logic [31:0] m_stat();
        return {m_txc, m_lvl, m_irq, 2'b00, m_ev};
    endfunction

    function automatic logic [31:0] m_read(input logic [3:0] a);
        case (a)
            4'd0, 4'd3: return m_stat();
            4'd1:       return m_mask;
            4'd2:       return {22'd0, m_clr};
            default:    return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ev = '0; m_lvl = '0; m_txc = '0; m_irq = 1'b0;
            m_mask = IMPL; m_clr = '0;
        end else begin
            t_st  = m_stat();
            t_irq = |(t_st & IMPL & ~m_mask);
            t_cl  = '0;
            if (bus_rd && bus_addr == 4'd0) t_cl = '1;
            else if (bus_rd && bus_addr == 4'd3) t_cl = m_clr;
            m_ev = (m_ev & ~t_cl) | evt_pulse;
            if (bus_wr && bus_addr == 4'd1) m_mask = bus_wdata & IMPL;
            if (bus_wr && bus_addr == 4'd2) m_clr = bus_wdata[9:0];
            m_lvl = src_level;
            m_txc = txc_index;
            m_irq = t_irq;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            check("R7 irq vs model", {31'd0, irq}, {31'd0, m_irq});
            check("R8 summary vs model", {31'd0, summary}, {31'd0, m_irq});
            check("R3 rdata vs model", bus_rdata, m_read(bus_addr));
        end
    end

    task automatic cyc(input logic [9:0] p, input logic rd, input logic wr,
                       input logic [3:0] a, input logic [31:0] d);
        @(posedge clk);
        #1;
        evt_pulse = p; bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
    endtask

    task automatic idle();
        cyc(10'd0, 1'b0, 1'b0, 4'd0, 32'd0);
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [31:0] m,
                          input logic [31:0] exp, input string tag);
        cyc(10'd0, 1'b1, 1'b0, a, 32'd0);
        @(negedge clk);
        check(tag, bus_rdata & m, exp);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        n_chk++;
        n_err++;
        $display("FAIL R1 watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        evt_pulse = '0; src_level = '0; txc_index = '0;
        bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset values
        idle();
        @(negedge clk);
        check("R1 irq after reset", {31'd0, irq}, 32'd0);
        rd_chk(4'd1, 32'hFFFFFFFF, IMPL, "R1 mask reset");
        rd_chk(4'd2, 32'hFFFFFFFF, 32'd0, "R1 clear-select reset");
        rd_chk(4'd0, 32'hFFFFFFFF, 32'd0, "R1 status reset");
        rd_chk(4'd7, 32'hFFFFFFFF, 32'd0, "R1 unused address");

        // R2 / R5 event latch and index copy, masked so no request
        txc_index = 13'h1ABC;
        cyc(10'h008, 1'b0, 1'b0, 4'd0, 32'd0);
        rd_chk(4'd0, 32'hFFFFFFFF, 32'hD5E00008, "R2 event bit 3 latched");
        check("R7 masked source no irq", {31'd0, irq}, 32'd0);
        rd_chk(4'd0, 32'hFFFFFFFF, 32'hD5E00000, "R3 cleared, R5 index kept");

        // R11 unmask everything
        cyc(10'd0, 1'b0, 1'b1, 4'd1, 32'd0);
        rd_chk(4'd1, 32'hFFFFFFFF, 32'd0, "R11 mask written");

        // R7 / R8 request timing
        cyc(10'h020, 1'b0, 1'b0, 4'd0, 32'd0);
        idle();
        @(negedge clk);
        check("R7 irq one cycle after status", {31'd0, irq}, 32'd0);
        idle();
        @(negedge clk);
        check("R7 irq raised", {31'd0, irq}, 32'd1);
        check("R8 summary raised", {31'd0, summary}, 32'd1);
        rd_chk(4'd0, 32'h00001FFF, 32'h00001020, "R8 status summary bit");
        idle();
        idle();
        @(negedge clk);
        check("R7 irq dropped after clear", {31'd0, irq}, 32'd0);

        // R4 level bits survive reads
        src_level = 6'b000101;
        idle();
        rd_chk(4'd0, 32'h0007E000, 32'h0000A000, "R4 level bits shown");
        rd_chk(4'd0, 32'h0007E000, 32'h0000A000, "R4 level bits not cleared");
        src_level = 6'd0;
        idle();
        rd_chk(4'd0, 32'h0007E000, 32'd0, "R4 level bits follow source");

        // R6 alias selective clear
        cyc(10'd0, 1'b0, 1'b1, 4'd2, 32'h00000003);
        rd_chk(4'd2, 32'hFFFFFFFF, 32'd3, "R11 clear-select written");
        cyc(10'h007, 1'b0, 1'b0, 4'd0, 32'd0);
        rd_chk(4'd3, 32'h000003FF, 32'h7, "R6 alias returns status");
        rd_chk(4'd3, 32'h000003FF, 32'h4, "R6 alias cleared selected only");
        rd_chk(4'd0, 32'h000003FF, 32'h4, "R3 plain read sees kept bit");
        rd_chk(4'd0, 32'h000003FF, 32'h0, "R3 plain read cleared");

        // R9 pulse meets clearing read
        cyc(10'h010, 1'b0, 1'b0, 4'd0, 32'd0);
        cyc(10'h050, 1'b1, 1'b0, 4'd0, 32'd0);
        @(negedge clk);
        check("R9 read shows pre-clear value", bus_rdata & 32'h3FF, 32'h010);
        rd_chk(4'd0, 32'h000003FF, 32'h050, "R9 colliding pulses kept");

        // R10 ignored writes and unimplemented bits
        cyc(10'd0, 1'b0, 1'b1, 4'd0, 32'hFFFFFFFF);
        cyc(10'd0, 1'b0, 1'b1, 4'd3, 32'hFFFFFFFF);
        rd_chk(4'd0, 32'h00000BFF, 32'd0, "R10 status write ignored");
        cyc(10'd0, 1'b0, 1'b1, 4'd1, 32'hFFFFFFFF);
        rd_chk(4'd1, 32'hFFFFFFFF, IMPL, "R10 mask unimplemented bits");
        cyc(10'd0, 1'b0, 1'b1, 4'd2, 32'hFFFFFFFF);
        rd_chk(4'd2, 32'hFFFFFFFF, 32'h3FF, "R10 clear-select unimplemented bits");
        cyc(10'h3FF, 1'b0, 1'b0, 4'd0, 32'd0);
        rd_chk(4'd0, 32'h00000FFF, 32'h3FF, "R10 bits 10 and 11 zero");
        rd_chk(4'd5, 32'hFFFFFFFF, 32'd0, "R10 unused address");

        // mixed traffic compared against the model every clock
        for (int k = 0; k < 3000; k++) begin
            logic [9:0] p;
            p = (($urandom % 3) == 0) ? 10'($urandom) & 10'($urandom) : 10'd0;
            if (($urandom % 16) == 0) src_level = 6'($urandom);
            if (($urandom % 8) == 0) txc_index = 13'($urandom);
            cyc(p, (($urandom % 4) == 0), (($urandom % 10) == 0),
                4'($urandom % 6), $urandom & $urandom);
        end
        idle();
        @(negedge clk);
        finish_run();
    end

endmodule